// File: doc/BRIEF.md
# DDS Control Word Loader

This block is the host-facing configuration port of a direct digital synthesizer. A host hands it a 40-bit configuration word in one of two ways. It can send five bytes on an 8-bit bus, one byte per rising edge of a word-clock strobe. Or it can send forty single bits, one per word-clock edge, taken from the top line of the same bus. The assembled word stays in an input register and does not reach the synthesizer until the host raises a separate update strobe. On that strobe the word is copied into the active tuning registers: a 32-bit frequency word, a 5-bit phase offset and a power-down flag.

Both strobes are asynchronous to the reference clock. Each passes through a synchronizer before its rising edge is detected. After reset the block runs in byte mode. Committing a control field of binary 11 switches it to bit-serial mode, and only a master reset brings it back. A master reset clears the active registers, the byte pointer and the mode. It leaves the input register untouched, so a word assembled before the reset can still be committed after it.

Top module: `dds_ctrl_loader`

## Requirements
- R1: While `rst` is high, and on release, `freqWord`, `phaseWord` and `powerDown` are all 0, the byte pointer is at the first slot (W0) and the block is in byte mode.
- R2: In byte mode the first byte written is the control slot. Its bits [1:0] are the control field, bit 2 is power-down and bits [7:3] are the phase word. The next four bytes are frequency bits [31:24], [23:16], [15:8] and [7:0], in that order. An update with control field 00 copies all of these fields to the outputs.
- R3: The outputs change only on an update strobe that commits. Writing bytes or bits alone leaves them unchanged.
- R4: After five bytes the pointer stays put, and further byte writes are ignored until the next update.
- R5: Every update strobe returns the pointer to the control slot, even if fewer than five bytes were written. Slots not written keep their earlier contents.
- R6: A control byte of binary 00000100 followed by an update sets `powerDown` to 1. A control byte with bit 2 at 0 and control field 00 followed by an update clears it.
- R7: In byte mode, an update whose control field is 01 or 10 changes no output.
- R8: An update whose control field is 11 enters bit-serial mode and leaves the outputs unchanged. The block stays in serial mode until reset.
- R9: In serial mode each word-clock edge shifts in `dataIn[7]`, and the first bit becomes W0. The forty bits map as follows: W0–W31 are the frequency word (LSB first), W32–W33 the control field, W34 power-down, and W35–W39 the phase word (LSB first).
- R10: In serial mode, an update whose W32/W33 are not both 0 changes no output.
- R11: Reset does not clear the input register. An update after reset, with no new data, commits the word assembled before the reset.
- R12: When a word-clock edge and an update edge are detected in the same cycle, the update commits the input register as it was before that cycle. The coinciding byte is discarded, and the pointer returns to the control slot.
- R13: Each strobe is synchronized through a two-flop chain. A strobe held high through reset is not taken as an edge after release, and edges detected in the first two cycles after release are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, active high, synchronous |
| dataIn | input | 8 | Byte bus; bit 7 carries serial data |
| wordClk | input | 1 | Word-clock strobe, asynchronous |
| updStrobe | input | 1 | Frequency-update strobe, asynchronous |
| freqWord | output | 32 | Active frequency tuning word |
| phaseWord | output | 5 | Active phase offset |
| powerDown | output | 1 | Active power-down flag |

## Verification
A word-clock edge and an update edge can be detected in the same cycle. Only one of them may then act. The bench causes this by raising both strobe pins at the same falling clock edge, so the two synchronizers see them in the same cycle. It first writes a new control byte, then raises both strobes together carrying a distinctive data byte. The outputs must then show the pre-existing frequency bytes and not that data byte. A following two-byte write must land in the control slot and the top frequency byte, which proves the pointer was cleared rather than advanced.

// File: rtl/dds_loader_pkg.sv
`timescale 1ns/1ps
package dds_loader_pkg;
  // word format
  localparam int FREQ_W    = 32;
  localparam int PHASE_W   = 5;
  localparam int CTL_W     = 2;
  localparam int BUS_W     = 8;
  localparam int WORD_W    = FREQ_W + CTL_W + 1 + PHASE_W;
  localparam int NUM_BYTES = WORD_W / BUS_W;
  localparam int PTR_W     = $clog2(NUM_BYTES + 1);
  // bit positions inside the assembled word (serial order, W0 at bit 0)
  localparam int CTL_LSB   = FREQ_W;
  localparam int PD_BIT    = FREQ_W + CTL_W;
  localparam int PHASE_LSB = PD_BIT + 1;

  localparam logic [CTL_W-1:0] CTL_RUN    = 2'b00;
  localparam logic [CTL_W-1:0] CTL_SERIAL = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic             writeByte;
    logic             shiftBit;
    logic             commit;
    logic [PTR_W-1:0] bytePtr;
  } loadStrb_t;
endpackage

// File: rtl/dds_edge_sync.sv
`timescale 1ns/1ps
module dds_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pinIn,
  output logic rise
);
  // free-running chain: keeps tracking the pin level through reset
  logic [STAGES-1:0] chain;
  logic              prevLvl;

  always_ff @(posedge clk) begin
    chain   <= {chain[STAGES-2:0], pinIn};
    prevLvl <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prevLvl;
endmodule

// File: rtl/dds_load_ctrl.sv
`timescale 1ns/1ps
module dds_load_ctrl
  import dds_loader_pkg::*;
#(
  parameter int RECOVER_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordRise,
  input  logic             updRise,
  input  logic [CTL_W-1:0] ctlBits,
  output loadStrb_t        strb,
  output logic             serialMode
);
  localparam int RC_W = $clog2(RECOVER_CYC + 2);
  localparam logic [RC_W-1:0]  RC_INIT  = RC_W'(RECOVER_CYC);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(NUM_BYTES);

  logic [RC_W-1:0]  recoverCnt;
  logic [PTR_W-1:0] bytePtr;
  logic             live, updOk, wordOk, ptrRoom;

  assign live    = (recoverCnt == '0);
  assign updOk   = updRise & live;
  assign wordOk  = wordRise & live & ~updOk;   // update wins a tie
  assign ptrRoom = (bytePtr < PTR_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      recoverCnt <= RC_INIT;
    end else if (!live) begin
      recoverCnt <= recoverCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bytePtr <= '0;
    end else if (updOk) begin
      bytePtr <= '0;
    end else if (wordOk && !serialMode && ptrRoom) begin
      bytePtr <= bytePtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      serialMode <= 1'b0;
    end else if (updOk && (ctlBits == CTL_SERIAL)) begin
      serialMode <= 1'b1;
    end
  end

  always_comb begin
    strb.writeByte = wordOk & ~serialMode & ptrRoom;
    strb.shiftBit  = wordOk & serialMode;
    strb.commit    = updOk & (ctlBits == CTL_RUN);
    strb.bytePtr   = bytePtr;
  end
endmodule

// File: rtl/dds_load_dp.sv
`timescale 1ns/1ps
module dds_load_dp
  import dds_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   dataIn,
  input  loadStrb_t          strb,
  output logic [CTL_W-1:0]   ctlBits,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown
);
  logic [WORD_W-1:0] inReg, nextReg;

  // slot 0 is the control byte at the top; slots 1.. are frequency bytes, MSB first
  function automatic int laneLsb(int slot);
    return (slot == 0) ? (WORD_W - BUS_W) : (FREQ_W - slot * BUS_W);
  endfunction

  always_comb begin
    nextReg = inReg;
    if (strb.shiftBit) begin
      nextReg = {dataIn[BUS_W-1], inReg[WORD_W-1:1]};
    end else if (strb.writeByte) begin
      for (int s = 0; s < NUM_BYTES; s++) begin
        if (strb.bytePtr == PTR_W'(s)) begin
          nextReg[laneLsb(s) +: BUS_W] = dataIn;
        end
      end
    end
  end

  // input register survives reset
  always_ff @(posedge clk) begin
    inReg <= nextReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freqWord  <= '0;
      phaseWord <= '0;
      powerDown <= 1'b0;
    end else if (strb.commit) begin
      freqWord  <= inReg[FREQ_W-1:0];
      phaseWord <= inReg[PHASE_LSB +: PHASE_W];
      powerDown <= inReg[PD_BIT];
    end
  end

  assign ctlBits = inReg[CTL_LSB +: CTL_W];
endmodule

// File: rtl/dds_ctrl_loader.sv
`timescale 1ns/1ps
module dds_ctrl_loader
  import dds_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RECOVER_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   dataIn,
  input  logic               wordClk,
  input  logic               updStrobe,
  output logic [FREQ_W-1:0]  freqWord,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               powerDown
);
  logic             wordRise, updRise, serialMode;
  logic [CTL_W-1:0] ctlBits;
  loadStrb_t        strb;

  dds_edge_sync #(.STAGES(SYNC_STAGES)) u_wordSync (
    .clk(clk), .pinIn(wordClk), .rise(wordRise)
  );

  dds_edge_sync #(.STAGES(SYNC_STAGES)) u_updSync (
    .clk(clk), .pinIn(updStrobe), .rise(updRise)
  );

  dds_load_ctrl #(.RECOVER_CYC(RECOVER_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .wordRise(wordRise), .updRise(updRise),
    .ctlBits(ctlBits), .strb(strb), .serialMode(serialMode)
  );

  dds_load_dp u_dp (
    .clk(clk), .rst(rst), .dataIn(dataIn), .strb(strb), .ctlBits(ctlBits),
    .freqWord(freqWord), .phaseWord(phaseWord), .powerDown(powerDown)
  );
endmodule

// File: rtl/dds_loader_checks.sv
`timescale 1ns/1ps
module dds_loader_checks
  import dds_loader_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [FREQ_W-1:0]  freqWord,
  input logic [PHASE_W-1:0] phaseWord,
  input logic               powerDown,
  input loadStrb_t          strb,
  input logic               serialMode
);
  // R1: a reset cycle leaves the active registers cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (freqWord == '0) && (phaseWord == '0) && !powerDown);

  // R3: without a commit the outputs hold
  assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(freqWord) && $stable(phaseWord) && $stable(powerDown));

  // R4: pointer never passes the last slot
  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
    strb.bytePtr <= PTR_W'(NUM_BYTES));

  // R8: serial mode is left only through reset
  assert_serial_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    serialMode |=> serialMode);

  // R12: a byte write never shares a cycle with a commit
  assert_single_action_R12: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.writeByte, strb.shiftBit, strb.commit}) <= 1);
endmodule

bind dds_ctrl_loader dds_loader_checks u_checks (
  .clk(clk), .rst(rst), .freqWord(freqWord), .phaseWord(phaseWord),
  .powerDown(powerDown), .strb(strb), .serialMode(serialMode)
);

// File: tb/test_dds_ctrl_loader.sv
`timescale 1ns/1ps
module test_dds_ctrl_loader;
  logic        clk = 1'b0, rst = 1'b1, wordClk = 1'b0, updStrobe = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [31:0] freqWord;
  logic [4:0]  phaseWord;
  logic        powerDown;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  dds_ctrl_loader i_dds_ctrl_loader (
    .clk(clk), .rst(rst), .dataIn(dataIn), .wordClk(wordClk), .updStrobe(updStrobe),
    .freqWord(freqWord), .phaseWord(phaseWord), .powerDown(powerDown)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(string req, logic [31:0] f, logic [4:0] p, logic pd);
    chk({req, " freq"}, 64'(freqWord), 64'(f));
    chk({req, " phase"}, 64'(phaseWord), 64'(p));
    chk({req, " pd"}, 64'(powerDown), 64'(pd));
  endtask

  task automatic pulseWord(logic [7:0] b);
    dataIn = b; wordClk = 1'b1; tick(3);
    wordClk = 1'b0; tick(2);
  endtask

  task automatic pulseUpd();
    updStrobe = 1'b1; tick(3);
    updStrobe = 1'b0; tick(2);
  endtask

  task automatic loadPar(logic [7:0] w0, logic [31:0] f);
    pulseWord(w0);
    pulseWord(f[31:24]); pulseWord(f[23:16]);
    pulseWord(f[15:8]);  pulseWord(f[7:0]);
  endtask

  task automatic sendSerial(logic [39:0] w);
    for (int i = 0; i < 40; i++) pulseWord({w[i], 7'h00});
  endtask

  task automatic doReset();
    rst = 1'b1; tick(6);
    rst = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    doReset();
    checkOut("R1 reset", 32'h0, 5'd0, 1'b0);
  endtask

  task automatic t_parallel();
    loadPar({5'd19, 1'b0, 2'b00}, 32'hDEADBEEF);
    checkOut("R3 no update yet", 32'h0, 5'd0, 1'b0);
    pulseUpd();
    checkOut("R2 byte load", 32'hDEADBEEF, 5'd19, 1'b0);
  endtask

  task automatic t_saturate();
    loadPar({5'd3, 1'b0, 2'b00}, 32'h12345678);
    pulseWord(8'hAA);
    pulseUpd();
    checkOut("R4 sixth byte dropped", 32'h12345678, 5'd3, 1'b0);
  endtask

  task automatic t_ptrReturn();
    pulseWord({5'd7, 1'b0, 2'b00});
    pulseWord(8'h11);
    pulseUpd();
    checkOut("R5 partial write", 32'h11345678, 5'd7, 1'b0);
    loadPar({5'd1, 1'b0, 2'b00}, 32'hA5A50F0F);
    pulseUpd();
    checkOut("R5 pointer at W0", 32'hA5A50F0F, 5'd1, 1'b0);
  endtask

  task automatic t_power();
    pulseWord(8'h04);
    pulseUpd();
    checkOut("R6 power down", 32'hA5A50F0F, 5'd0, 1'b1);
    pulseWord(8'h08);
    pulseUpd();
    checkOut("R6 power up", 32'hA5A50F0F, 5'd1, 1'b0);
  endtask

  task automatic t_ctlIgnore();
    loadPar(8'h01, 32'h0BAD0BAD);
    pulseUpd();
    checkOut("R7 control 01", 32'hA5A50F0F, 5'd1, 1'b0);
    pulseWord({5'd9, 1'b0, 2'b10});
    pulseUpd();
    checkOut("R7 control 10", 32'hA5A50F0F, 5'd1, 1'b0);
  endtask

  task automatic t_simul();
    loadPar({5'd2, 1'b0, 2'b00}, 32'hCAFEF00D);
    pulseUpd();
    checkOut("R2 second load", 32'hCAFEF00D, 5'd2, 1'b0);
    pulseWord({5'd3, 1'b0, 2'b00});
    dataIn = 8'h77; wordClk = 1'b1; updStrobe = 1'b1; tick(3);
    wordClk = 1'b0; updStrobe = 1'b0; tick(2);
    checkOut("R12 update wins", 32'hCAFEF00D, 5'd3, 1'b0);
    pulseWord({5'd4, 1'b0, 2'b00});
    pulseWord(8'h99);
    pulseUpd();
    checkOut("R12 pointer cleared", 32'h99FEF00D, 5'd4, 1'b0);
  endtask

  task automatic t_serial();
    pulseWord(8'h03);
    pulseUpd();
    checkOut("R8 serial entry", 32'h99FEF00D, 5'd4, 1'b0);
    sendSerial({5'd21, 1'b0, 2'b00, 32'h13579BDF});
    checkOut("R3 serial no update", 32'h99FEF00D, 5'd4, 1'b0);
    pulseUpd();
    checkOut("R9 serial load", 32'h13579BDF, 5'd21, 1'b0);
    sendSerial({5'd6, 1'b1, 2'b00, 32'h00000042});
    pulseUpd();
    checkOut("R9 serial power down", 32'h00000042, 5'd6, 1'b1);
    sendSerial({5'd30, 1'b0, 2'b01, 32'hFFFF0000});
    pulseUpd();
    checkOut("R10 bad control", 32'h00000042, 5'd6, 1'b1);
    sendSerial({5'd30, 1'b0, 2'b11, 32'hFFFF0000});
    pulseUpd();
    checkOut("R10 control 11", 32'h00000042, 5'd6, 1'b1);
    sendSerial({5'd12, 1'b0, 2'b00, 32'h0F1E2D3C});
    pulseUpd();
    checkOut("R8 still serial", 32'h0F1E2D3C, 5'd12, 1'b0);
  endtask

  task automatic t_resetKeep();
    sendSerial({5'd11, 1'b0, 2'b00, 32'h2468ACE0});
    doReset();
    checkOut("R1 reset clears", 32'h0, 5'd0, 1'b0);
    pulseUpd();
    checkOut("R11 input kept", 32'h2468ACE0, 5'd11, 1'b0);
    loadPar({5'd5, 1'b0, 2'b00}, 32'h0000FFFF);
    pulseUpd();
    checkOut("R1 byte mode after reset", 32'h0000FFFF, 5'd5, 1'b0);
  endtask

  task automatic t_heldStrobe();
    rst = 1'b1; tick(2);
    dataIn = 8'hFF; wordClk = 1'b1; tick(5);
    rst = 1'b0; tick(6);
    wordClk = 1'b0; tick(3);
    loadPar({5'd6, 1'b0, 2'b00}, 32'h76543210);
    pulseUpd();
    checkOut("R13 held level ignored", 32'h76543210, 5'd6, 1'b0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_parallel();
    t_saturate();
    t_ptrReturn();
    t_power();
    t_ctlIgnore();
    t_simul();
    t_serial();
    t_resetKeep();
    t_heldStrobe();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule